// File: doc/BRIEF.md
# Dithered Fractional Phase Accumulator

This block is the digital core of a direct digital synthesizer whose tuning resolution goes 16 bits past its 48-bit phase accumulator. It does not widen the accumulator. It keeps two active increments, a base word and the base word plus one. A 16-bit pulse-width pattern decides on every sample which of the two is added. Averaged over one 65536-sample dither period, the phase then advances by the base word plus a 16-bit fraction of one LSB. This gives the effect of a 64-bit tuning word.

Software writes a single 64-bit tuning value. The upper 48 bits are the base increment and the lower 16 bits are the duty, the number of samples per period that use the larger increment. A written value waits in a staging register. It becomes active only when the free-running dither counter wraps, so every period runs with one consistent pair of words and one duty. The accumulator phase is available at a port. A quarter-wave sine table turns the top accumulator bits into a 12-bit offset-binary amplitude word that a converter downstream can use.

Top module: `frac_dds_core`

## Requirements
- R1: While reset is asserted and at its release, the phase output is 0 and the sample output is 2048 (mid-code). The active base word is 0, the active upper word is 1, the duty is 0 and the dither counter is 0.
- R2: A write puts wr_word_i[63:16] into the staged base word and wr_word_i[15:0] into the staged duty. If several writes arrive in one period, the last one wins. Staged values become active only on the edge where the dither counter goes from 65535 to 0. A write on that same edge is staged for the following period, and the active values do not change at any other edge.
- R3: The dither counter counts 0..65535 on each sample and wraps. On each sample the phase advances modulo 2^48 by the upper word when the counter is below the duty, and by the base word otherwise.
- R4: A duty of 0 selects the base word on every sample of the period.
- R5: The upper word is computed internally as base+1 modulo 2^48, so a base of all ones gives an upper word of 0.
- R6: Over one full dither period, the phase advances by 65536 × base + duty modulo 2^48.
- R7: The sample output updates one cycle after the phase it represents. Let q = phase[47:46], i = phase[45:38] and N = 256. Take j = i when q is 0 or 2, and j = N − i when q is 1 or 3. Let u = j(2N − j) and mag = floor(4·2047·u / (5N² − u)). The sample is 2048 + mag when q < 2 and 2048 − mag otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock (100 MHz, five times a 20 MHz reference) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Stage the tuning value on this edge |
| wr_word_i | input | 64 | Tuning value: [63:16] base word, [15:0] duty |
| phase_o | output | 48 | Phase accumulator value |
| sample_o | output | 12 | Offset-binary amplitude word |

## Verification
A wrong active word, a misplaced select or a bad carry into the upper word shows up on phase_o as a wrong increment on the very next edge. The bench therefore compares every sample's increment against its own model of the counter and the staged words. An error in the counter length or in the load timing may leave each single step plausible, but it breaks the period total after 65536 samples, so the bench also checks that total. Errors in the table or the folding show up on sample_o one edge after the phase that caused them, and the bench checks every sample against the stated formula.

// File: rtl/frac_dds_pkg.sv
package frac_dds_pkg;

    // Rational quarter-wave sine approximation for table point j of n.
    // Exact at j = 0 (0) and j = n (peak).
    function automatic int unsigned sine_mag(input int unsigned j,
                                             input int unsigned n,
                                             input int unsigned peak);
        longint unsigned u;
        longint unsigned num;
        longint unsigned den;
        u   = 64'(j) * 64'(2 * n - j);
        num = 64'(4) * 64'(peak) * u;
        den = 64'(5) * 64'(n) * 64'(n) - u;
        return 32'(num / den);
    endfunction

endpackage

// File: rtl/frac_dds_ctrl.sv
module frac_dds_ctrl #(
    parameter int ACC_W  = 48,
    parameter int FRAC_W = 16
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    wr_en_i,
    input  logic [ACC_W+FRAC_W-1:0] wr_word_i,
    output logic [ACC_W-1:0]        inc_o,
    output logic                    sel_o,
    output logic [FRAC_W-1:0]       cnt_o,
    output logic [FRAC_W-1:0]       duty_o,
    output logic [ACC_W-1:0]        base_o,
    output logic [ACC_W-1:0]        plus_o
);

    localparam logic [FRAC_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [ACC_W-1:0]  pend_base;
        logic [FRAC_W-1:0] pend_duty;
        logic [ACC_W-1:0]  base;
        logic [ACC_W-1:0]  plus;
        logic [FRAC_W-1:0] duty;
        logic [FRAC_W-1:0] cnt;
    } ctrl_t;

    ctrl_t s_d;
    ctrl_t s_q;
    logic  sel;

    always_comb begin
        s_d     = s_q;
        s_d.cnt = s_q.cnt + 1'b1;
        // Period boundary: move staged values into the active set.
        if (s_q.cnt == CNT_MAX) begin
            s_d.base = s_q.pend_base;
            s_d.plus = s_q.pend_base + 1'b1;
            s_d.duty = s_q.pend_duty;
        end
        if (wr_en_i) begin
            s_d.pend_base = wr_word_i[ACC_W+FRAC_W-1:FRAC_W];
            s_d.pend_duty = wr_word_i[FRAC_W-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.pend_base <= '0;
            s_q.pend_duty <= '0;
            s_q.base      <= '0;
            s_q.plus      <= ACC_W'(1);
            s_q.duty      <= '0;
            s_q.cnt       <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sel    = (s_q.cnt < s_q.duty);
    assign inc_o  = sel ? s_q.plus : s_q.base;
    assign sel_o  = sel;
    assign cnt_o  = s_q.cnt;
    assign duty_o = s_q.duty;
    assign base_o = s_q.base;
    assign plus_o = s_q.plus;

endmodule

// File: rtl/frac_dds_accum.sv
module frac_dds_accum #(
    parameter int ACC_W = 48
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [ACC_W-1:0] inc_i,
    output logic [ACC_W-1:0] phase_o
);

    logic [ACC_W-1:0] phase_d;
    logic [ACC_W-1:0] phase_q;

    always_comb begin
        phase_d = phase_q + inc_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_d;
        end
    end

    assign phase_o = phase_q;

endmodule

// File: rtl/frac_dds_sine.sv
module frac_dds_sine #(
    parameter int AMP_W  = 12,
    parameter int QTR_AW = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [QTR_AW+1:0] phase_top_i,
    output logic [AMP_W-1:0]  sample_o
);

    localparam int             QTR_N = 1 << QTR_AW;
    localparam int             PEAK  = (1 << (AMP_W - 1)) - 1;
    localparam logic [AMP_W-1:0] MID = AMP_W'(1 << (AMP_W - 1));

    logic [AMP_W-1:0]  rom [0:QTR_N];
    logic [1:0]        quad;
    logic [QTR_AW-1:0] idx;
    logic [QTR_AW:0]   addr;
    logic [AMP_W-1:0]  mag;
    logic [AMP_W-1:0]  sample_d;
    logic [AMP_W-1:0]  sample_q;

    // Table of QTR_N+1 points so both ends of the quarter are exact.
    for (genvar g = 0; g <= QTR_N; g++) begin : g_rom
        assign rom[g] = AMP_W'(frac_dds_pkg::sine_mag(g, QTR_N, PEAK));
    end

    always_comb begin
        quad = phase_top_i[QTR_AW+1:QTR_AW];
        idx  = phase_top_i[QTR_AW-1:0];
        // Odd quadrants run the quarter backwards.
        addr = quad[0] ? ((QTR_AW+1)'(QTR_N) - {1'b0, idx}) : {1'b0, idx};
        mag  = rom[addr];
        // Upper half of the cycle is the negative lobe.
        sample_d = quad[1] ? (MID - mag) : (MID + mag);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sample_q <= MID;
        end else begin
            sample_q <= sample_d;
        end
    end

    assign sample_o = sample_q;

endmodule

// File: rtl/frac_dds_core.sv
module frac_dds_core #(
    parameter int ACC_W  = 48,
    parameter int FRAC_W = 16,
    parameter int AMP_W  = 12,
    parameter int QTR_AW = 8
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    wr_en_i,
    input  logic [ACC_W+FRAC_W-1:0] wr_word_i,
    output logic [ACC_W-1:0]        phase_o,
    output logic [AMP_W-1:0]        sample_o
);

    localparam int TOP_W = QTR_AW + 2;

    logic [ACC_W-1:0]  inc_w;
    logic              sel_w;
    logic [FRAC_W-1:0] cnt_w;
    logic [FRAC_W-1:0] duty_w;
    logic [ACC_W-1:0]  base_w;
    logic [ACC_W-1:0]  plus_w;
    logic [ACC_W-1:0]  phase_w;

    frac_dds_ctrl #(
        .ACC_W (ACC_W),
        .FRAC_W(FRAC_W)
    ) u_ctrl (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (wr_en_i),
        .wr_word_i(wr_word_i),
        .inc_o    (inc_w),
        .sel_o    (sel_w),
        .cnt_o    (cnt_w),
        .duty_o   (duty_w),
        .base_o   (base_w),
        .plus_o   (plus_w)
    );

    frac_dds_accum #(
        .ACC_W(ACC_W)
    ) u_accum (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .inc_i  (inc_w),
        .phase_o(phase_w)
    );

    frac_dds_sine #(
        .AMP_W (AMP_W),
        .QTR_AW(QTR_AW)
    ) u_sine (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .phase_top_i(phase_w[ACC_W-1 -: TOP_W]),
        .sample_o   (sample_o)
    );

    assign phase_o = phase_w;

endmodule

// File: rtl/frac_dds_chk.sv
module frac_dds_chk #(
    parameter int ACC_W  = 48,
    parameter int FRAC_W = 16,
    parameter int AMP_W  = 12,
    parameter int QTR_AW = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              sel_w,
    input logic [FRAC_W-1:0] cnt_w,
    input logic [FRAC_W-1:0] duty_w,
    input logic [ACC_W-1:0]  base_w,
    input logic [ACC_W-1:0]  plus_w,
    input logic [ACC_W-1:0]  phase_o,
    input logic [AMP_W-1:0]  sample_o
);

    localparam logic [FRAC_W-1:0] CNT_MAX = '1;
    localparam logic [AMP_W-1:0]  MID     = AMP_W'(1 << (AMP_W - 1));
    localparam int                TOP_W   = QTR_AW + 2;

    AST_HOLD_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_w != CNT_MAX) |=> ($stable(duty_w) && $stable(base_w) && $stable(plus_w))); // R2

    AST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (phase_o == $past(phase_o) + $past(sel_w ? plus_w : base_w))); // R3

    AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_w == CNT_MAX) |=> (cnt_w == '0)); // R3

    AST_ZERO_DUTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (duty_w == '0) |-> !sel_w); // R4

    AST_PLUS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        plus_w == base_w + 1'b1); // R5

    AST_SAMPLE_MID: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(phase_o[ACC_W-1 -: TOP_W] == '0) |-> (sample_o == MID)); // R7

endmodule

bind frac_dds_core frac_dds_chk #(
    .ACC_W (ACC_W),
    .FRAC_W(FRAC_W),
    .AMP_W (AMP_W),
    .QTR_AW(QTR_AW)
) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_w   (sel_w),
    .cnt_w   (cnt_w),
    .duty_w  (duty_w),
    .base_w  (base_w),
    .plus_w  (plus_w),
    .phase_o (phase_o),
    .sample_o(sample_o)
);

// File: tb/frac_dds_core_bench.sv
module frac_dds_core_bench;

    localparam logic [47:0] FTW_A   = 48'h0123_4567_89AB;
    localparam logic [15:0] DUTY_A  = 16'h1234;
    localparam logic [47:0] FTW_B   = 48'hFFFF_FFFF_FFFF;
    localparam logic [15:0] DUTY_B  = 16'h0000;
    localparam logic [63:0] W_JUNK  = {48'h5555_5555_5555, 16'hAAAA};
    localparam logic [63:0] W_LATE  = {48'h0DEA_D000_0BEE, 16'h0777};

    logic        clk_i = 1'b0;
    logic        rst_ni;
    logic        wr_en_i;
    logic [63:0] wr_word_i;
    logic [47:0] phase_o;
    logic [11:0] sample_o;

    int checks = 0;
    int fails  = 0;
    int kcnt   = 0;
    int wdog   = 0;
    bit run_mon = 1'b0;

    // Bench model state, built from the requirements.
    int          m_cnt = 0;
    logic [47:0] m_base = '0;
    logic [15:0] m_duty = '0;
    logic [47:0] m_pbase = '0;
    logic [15:0] m_pduty = '0;
    logic [47:0] m_phase = '0;
    logic [47:0] m_prev = '0;
    int          err_step = 0;
    int          err_sine = 0;
    logic [47:0] p1_end;

    always #5 clk_i = ~clk_i;

    frac_dds_core u_frac_dds_core (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (wr_en_i),
        .wr_word_i(wr_word_i),
        .phase_o  (phase_o),
        .sample_o (sample_o)
    );

    function automatic logic [11:0] ref_sample(input logic [47:0] p);
        int      q;
        int      i;
        longint  j;
        longint  u;
        longint  m;
        q = int'(p[47:46]);
        i = int'(p[45:38]);
        j = (q % 2 == 1) ? longint'(256 - i) : longint'(i);
        u = j * (512 - j);
        m = (4 * 2047 * u) / (5 * 65536 - u);
        return (q >= 2) ? 12'(2048 - m) : 12'(2048 + m);
    endfunction

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk_i) begin
        if (rst_ni) kcnt++;
        wdog++;
        if (wdog > 199500) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<199500", wdog);
            report();
        end
    end

    // Per-sample model for R3 and R7.
    always @(negedge clk_i) begin
        if (run_mon) begin
            m_phase = m_phase + ((m_cnt < int'(m_duty)) ? (m_base + 48'd1) : m_base);
            if (phase_o !== m_phase) err_step++;
            if (sample_o !== ref_sample(m_prev)) err_sine++;
            if (m_cnt == 65535) begin
                m_base = m_pbase;
                m_duty = m_pduty;
            end
            m_cnt = (m_cnt + 1) % 65536;
            if (wr_en_i) begin
                m_pbase = wr_word_i[63:16];
                m_pduty = wr_word_i[15:0];
            end
            m_prev = phase_o;
        end
    end

    task automatic wait_k(input int k);
        do @(negedge clk_i); while (kcnt < k);
        #1;
    endtask

    // Drive a write that the core captures on edge k+1.
    task automatic write_at(input int k, input logic [63:0] w);
        wait_k(k);
        #1;
        wr_en_i   = 1'b1;
        wr_word_i = w;
        @(negedge clk_i);
        #2;
        wr_en_i   = 1'b0;
        wr_word_i = '0;
    endtask

    task automatic t_reset;
        rst_ni    = 1'b0;
        wr_en_i   = 1'b0;
        wr_word_i = '0;
        repeat (3) @(negedge clk_i);
        chk(phase_o == 48'd0, "R1 reset phase", 64'(phase_o), 64'd0);
        chk(sample_o == 12'd2048, "R1 reset sample", 64'(sample_o), 64'd2048);
        rst_ni = 1'b1;
        #1 run_mon = 1'b1;
        wait_k(1);
        chk(phase_o == 48'd0, "R1 first step adds active base 0", 64'(phase_o), 64'd0);
    endtask

    task automatic t_staging;
        write_at(10, W_JUNK);
        write_at(20, {FTW_A, DUTY_A});
        wait_k(30000);
        chk(phase_o == 48'd0, "R2 staged write not active mid-period", 64'(phase_o), 64'd0);
        write_at(65535, W_LATE);
        chk(phase_o == 48'd0, "R2 period 0 used reset words", 64'(phase_o), 64'd0);
        wait_k(65537);
        chk(phase_o == FTW_A + 48'd1, "R2 last write active after wrap", 64'(phase_o),
            64'(FTW_A + 48'd1));
    endtask

    task automatic t_mid_duty;
        logic [47:0] e;
        write_at(70000, {FTW_B, DUTY_B});
        wait_k(65536 + int'(DUTY_A));
        e = (FTW_A + 48'd1) * 48'(DUTY_A);
        chk(phase_o == e, "R3 upper word while counter below duty", 64'(phase_o), 64'(e));
        wait_k(65536 + int'(DUTY_A) + 1);
        e = e + FTW_A;
        chk(phase_o == e, "R3 base word once counter reaches duty", 64'(phase_o), 64'(e));
        wait_k(131072);
        e = (FTW_A << 16) + 48'(DUTY_A);
        chk(phase_o == e, "R6 period total base*65536+duty", 64'(phase_o), 64'(e));
        p1_end = phase_o;
    endtask

    task automatic t_zero_duty_wrap;
        logic [47:0] e;
        wait_k(131073);
        e = p1_end - 48'd1;
        chk(phase_o == e, "R4 R5 zero duty adds all-ones base", 64'(phase_o), 64'(e));
        wait_k(160000);
        e = p1_end - 48'd28928;
        chk(phase_o == e, "R4 no upper-word step in zero-duty period", 64'(phase_o), 64'(e));
        wait_k(196608);
        e = p1_end - 48'd65536;
        chk(phase_o == e, "R6 R5 period total with wrapped upper word", 64'(phase_o), 64'(e));
    endtask

    task automatic t_model_totals;
        chk(err_step == 0, "R3 per-sample increments", 64'(err_step), 64'd0);
        chk(err_sine == 0, "R7 per-sample amplitude", 64'(err_sine), 64'd0);
    endtask

    initial begin
        t_reset();
        t_staging();
        t_mid_duty();
        t_zero_duty_wrap();
        t_model_totals();
        report();
    end

endmodule